// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block couples two bidirectional data ports, A and B, each split into independent byte lanes. Every lane carries its own active-low enable, a direction bit, two capture strobes and two source selects. When a lane is enabled, the direction bit picks which port drives. The driving port carries either the live value arriving on the other port or a value that lane captured earlier. Each port is presented for synthesis as a separate input bus, output bus and per-lane drive enable. A pad-level wrapper can merge these into tri-state pins.

Each lane holds two registers. The forward register samples port A and feeds port B. The reverse register samples port B and feeds port A. A capture strobe is sampled in the system clock domain, and a register loads on the first clock where its strobe is seen high after being low. Captures run whatever the enable and direction settings are. A lane can therefore store traffic while it is isolated and replay it later.

Each lane decodes a mode every cycle. MODE_ISOLATE applies while its enable is high. MODE_DRIVE_B applies when the lane is enabled with direction 1. MODE_DRIVE_A applies when it is enabled with direction 0. The lane moves between these modes combinationally in the same cycle its enable or direction changes: ISOLATE to DRIVE_B, ISOLATE to DRIVE_A, DRIVE_B to DRIVE_A, and each reverse.

Top module: `regbus_xcvr`

## Requirements
- R1: A synchronous active-high reset clears both registers of every lane to zero, so a stored-mode output reads 0 after reset until a capture occurs.
- R2: While a lane's oe_n bit is 1, neither a_drive_en nor b_drive_en of that lane is set.
- R3: With oe_n 0 and dir 1, a lane sets b_drive_en and clears a_drive_en.
- R4: With oe_n 0 and dir 0, a lane sets a_drive_en and clears b_drive_en.
- R5: The two drive enables of a lane are never set together.
- R6: On a clock where cap_ab is 1 and was 0 at the previous clock, the forward register loads that lane's a_in byte. cap_ba loads b_in into the reverse register by the same rule.
- R7: Captures take place whatever the values of oe_n and dir are, including in isolation.
- R8: With sel_ab 0, a driven port B shows the lane's a_in byte in the same cycle. With sel_ba 0, a driven port A shows b_in.
- R9: With sel_ab 1 (or sel_ba 1), the driven port shows the forward (or reverse) register. A capture is visible from the cycle after its clock edge.
- R10: A strobe held high loads only once. A strobe already high when reset releases loads nothing until it goes low and high again.
- R11: The forward and reverse registers of a lane may capture on the same clock.
- R12: Lanes are independent. Lane l uses bits [8l+7:8l] of every data bus and bit l of every control and enable vector.
- R13: An undriven output bus lane reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| oe_n | input | LANES | Lane enable, active low |
| dir | input | LANES | 1: B driven from A side; 0: A driven from B side |
| cap_ab | input | LANES | Forward capture strobe (samples port A) |
| cap_ba | input | LANES | Reverse capture strobe (samples port B) |
| sel_ab | input | LANES | Port B source: 0 live, 1 stored |
| sel_ba | input | LANES | Port A source: 0 live, 1 stored |
| a_in | input | LANES*LANE_W | Port A receive data |
| a_out | output | LANES*LANE_W | Port A drive data |
| a_drive_en | output | LANES | Port A drive enable per lane |
| b_in | input | LANES*LANE_W | Port B receive data |
| b_out | output | LANES*LANE_W | Port B drive data |
| b_drive_en | output | LANES | Port B drive enable per lane |

## Verification
The bench builds the block with its defaults of two lanes of eight bits. This exposes the lane boundary at bit 8, where a slicing error would mix the lanes. Directed phases pair one lane that is active with the other one isolated. A long stretch of random control and data then drives all three lane modes, mode changes and overlapping captures across both lanes.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    typedef enum logic [1:0] {
        MODE_ISOLATE = 2'd0,
        MODE_DRIVE_B = 2'd1,
        MODE_DRIVE_A = 2'd2
    } lane_mode_t;
endpackage

// File: rtl/xcvr_strobe_edge.sv
module xcvr_strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= strobe;
    end

    assign rise = strobe && !prev_q;

    // R10: a strobe seen high on two clocks in a row does not rise again
    a_r10_single_rise: assert property (@(posedge clk) disable iff (rst)
        (strobe && $past(strobe)) |-> !rise);
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

    // R6: a load takes the data present at that edge
    a_r6_load_value: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(d)));
    // R10: without a load the stored value holds
    a_r10_hold_value: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              oe_n,
    input  logic              dir,
    input  logic              cap_ab,
    input  logic              cap_ba,
    input  logic              sel_ab,
    input  logic              sel_ba,
    input  logic [LANE_W-1:0] a_in,
    input  logic [LANE_W-1:0] b_in,
    output logic [LANE_W-1:0] a_out,
    output logic              a_en,
    output logic [LANE_W-1:0] b_out,
    output logic              b_en
);
    logic              rise_ab, rise_ba;
    logic [LANE_W-1:0] fwd_q, rev_q;
    lane_mode_t        mode;

    xcvr_strobe_edge u_edge_ab (.clk(clk), .rst(rst), .strobe(cap_ab), .rise(rise_ab));
    xcvr_strobe_edge u_edge_ba (.clk(clk), .rst(rst), .strobe(cap_ba), .rise(rise_ba));

    xcvr_store #(.WIDTH(LANE_W)) u_fwd (
        .clk(clk), .rst(rst), .load(rise_ab), .d(a_in), .q(fwd_q));
    xcvr_store #(.WIDTH(LANE_W)) u_rev (
        .clk(clk), .rst(rst), .load(rise_ba), .d(b_in), .q(rev_q));

    always_comb begin
        if (oe_n)     mode = MODE_ISOLATE;
        else if (dir) mode = MODE_DRIVE_B;
        else          mode = MODE_DRIVE_A;
    end

    always_comb begin
        a_out = '0;
        b_out = '0;
        a_en  = 1'b0;
        b_en  = 1'b0;
        unique case (mode)
            MODE_ISOLATE: ;
            MODE_DRIVE_B: begin
                b_en  = 1'b1;
                b_out = sel_ab ? fwd_q : a_in;
            end
            MODE_DRIVE_A: begin
                a_en  = 1'b1;
                a_out = sel_ba ? rev_q : b_in;
            end
            default: ;
        endcase
    end

    // R5: one driver per lane
    a_r5_one_driver: assert property (@(posedge clk) disable iff (rst)
        !(a_en && b_en));
    // R13: undriven side carries zero
    a_r13_quiet_b: assert property (@(posedge clk) disable iff (rst)
        !b_en |-> (b_out == '0));
    a_r13_quiet_a: assert property (@(posedge clk) disable iff (rst)
        !a_en |-> (a_out == '0));
    // R9: stored replay shows the value captured one clock earlier
    a_r9_replay: assert property (@(posedge clk) disable iff (rst)
        (rise_ab && !oe_n && dir && sel_ab) ##1 (!oe_n && dir && sel_ab)
            |-> (b_out == $past(a_in)));
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int BUS_W = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] oe_n,
    input  logic [LANES-1:0] dir,
    input  logic [LANES-1:0] cap_ab,
    input  logic [LANES-1:0] cap_ba,
    input  logic [LANES-1:0] sel_ab,
    input  logic [LANES-1:0] sel_ba,
    input  logic [BUS_W-1:0] a_in,
    output logic [BUS_W-1:0] a_out,
    output logic [LANES-1:0] a_drive_en,
    input  logic [BUS_W-1:0] b_in,
    output logic [BUS_W-1:0] b_out,
    output logic [LANES-1:0] b_drive_en
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        xcvr_lane #(.LANE_W(LANE_W)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .oe_n  (oe_n[l]),
            .dir   (dir[l]),
            .cap_ab(cap_ab[l]),
            .cap_ba(cap_ba[l]),
            .sel_ab(sel_ab[l]),
            .sel_ba(sel_ba[l]),
            .a_in  (a_in[l*LANE_W +: LANE_W]),
            .b_in  (b_in[l*LANE_W +: LANE_W]),
            .a_out (a_out[l*LANE_W +: LANE_W]),
            .a_en  (a_drive_en[l]),
            .b_out (b_out[l*LANE_W +: LANE_W]),
            .b_en  (b_drive_en[l])
        );

        // R2: isolated lane drives neither port
        a_r2_isolated: assert property (@(posedge clk) disable iff (rst)
            oe_n[l] |-> (!a_drive_en[l] && !b_drive_en[l]));
        // R3: direction 1 drives B only
        a_r3_drive_b: assert property (@(posedge clk) disable iff (rst)
            (!oe_n[l] && dir[l]) |-> (b_drive_en[l] && !a_drive_en[l]));
        // R4: direction 0 drives A only
        a_r4_drive_a: assert property (@(posedge clk) disable iff (rst)
            (!oe_n[l] && !dir[l]) |-> (a_drive_en[l] && !b_drive_en[l]));
        // R8: live pass-through in the same cycle
        a_r8_live_b: assert property (@(posedge clk) disable iff (rst)
            (b_drive_en[l] && !sel_ab[l]) |->
                (b_out[l*LANE_W +: LANE_W] == a_in[l*LANE_W +: LANE_W]));
        a_r8_live_a: assert property (@(posedge clk) disable iff (rst)
            (a_drive_en[l] && !sel_ba[l]) |->
                (a_out[l*LANE_W +: LANE_W] == b_in[l*LANE_W +: LANE_W]));
    end
endmodule

// File: tb/regbus_xcvr_tb_top.sv
module regbus_xcvr_tb_top;
    localparam int LANES = 2;
    localparam int LW    = 8;
    localparam int BW    = LANES * LW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [LANES-1:0] oe_n = '1, dir = '0, cap_ab = '0, cap_ba = '0, sel_ab = '0, sel_ba = '0;
    logic [BW-1:0] a_in = '0, b_in = '0;
    logic [BW-1:0] a_out, b_out;
    logic [LANES-1:0] a_drive_en, b_drive_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [LW-1:0] m_fwd [LANES];
    logic [LW-1:0] m_rev [LANES];
    bit            m_pab [LANES];
    bit            m_pba [LANES];

    always #4 clk = ~clk;

    regbus_xcvr #(.LANES(LANES), .LANE_W(LW)) dut_i (
        .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir),
        .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_in), .a_out(a_out), .a_drive_en(a_drive_en),
        .b_in(b_in), .b_out(b_out), .b_drive_en(b_drive_en));

    // behavioural reference: registers load on a low-to-high strobe seen at a clock
    always @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (rst) begin
                m_fwd[l] = '0; m_rev[l] = '0; m_pab[l] = 1; m_pba[l] = 1;
            end else begin
                if (cap_ab[l] && !m_pab[l]) m_fwd[l] = a_in[l*LW +: LW];
                if (cap_ba[l] && !m_pba[l]) m_rev[l] = b_in[l*LW +: LW];
                m_pab[l] = cap_ab[l];
                m_pba[l] = cap_ba[l];
            end
        end
    end

    task automatic cmp(string tag, string what, int l, logic [LW-1:0] act, logic [LW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s lane%0d %s actual=%h expected=%h at %0t", tag, l, what, act, exp, $time);
        end
    endtask

    task automatic check(string tag);
        for (int l = 0; l < LANES; l++) begin
            bit ea, eb;
            logic [LW-1:0] xa, xb;
            ea = !oe_n[l] && !dir[l];
            eb = !oe_n[l] && dir[l];
            xa = ea ? (sel_ba[l] ? m_rev[l] : b_in[l*LW +: LW]) : '0;
            xb = eb ? (sel_ab[l] ? m_fwd[l] : a_in[l*LW +: LW]) : '0;
            cmp(tag, "a_drive_en", l, {7'd0, a_drive_en[l]}, {7'd0, ea});
            cmp(tag, "b_drive_en", l, {7'd0, b_drive_en[l]}, {7'd0, eb});
            cmp(tag, "a_out", l, a_out[l*LW +: LW], xa);
            cmp(tag, "b_out", l, b_out[l*LW +: LW], xb);
        end
    endtask

    task automatic run(string tag);
        #2 check(tag);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 50000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        @(negedge clk);
        run("R1"); run("R1");
        rst = 0;
        // R1: stored sources read zero after reset while live inputs are all ones
        oe_n = 2'b00; dir = 2'b01; sel_ab = '1; sel_ba = '1;
        a_in = 16'hFFFF; b_in = 16'hFFFF;
        cap_ab = 2'b11;               // R10: strobe high right out of reset
        run("R1"); run("R10");
        cap_ab = '0; run("R10");
        // R8: transparent paths
        sel_ab = '0; sel_ba = '0;
        a_in = 16'h1234; run("R8");
        a_in = 16'hA5C3; b_in = 16'h9E00; run("R8");
        // R6 / R9: capture then replay on lane 0
        sel_ab = 2'b01; a_in = 16'h005A; cap_ab = 2'b01; run("R6");
        a_in = 16'h0077; run("R9");
        run("R10");
        cap_ab = '0; run("R9");
        cap_ab = 2'b01; run("R6");
        cap_ab = '0; run("R9");
        // R4: reverse path stored
        dir = 2'b00; sel_ba = 2'b01; b_in = 16'h4D3C; cap_ba = 2'b01; run("R4");
        cap_ba = '0; b_in = 16'h0000; run("R9");
        // R7 / R11: capture both ways while isolated
        oe_n = 2'b11; a_in = 16'hC0DE; b_in = 16'hBEEF;
        cap_ab = 2'b11; cap_ba = 2'b11; run("R7");
        run("R2"); run("R13");
        cap_ab = '0; cap_ba = '0; a_in = '0; b_in = '0;
        oe_n = 2'b00; dir = 2'b01; sel_ab = '1; sel_ba = '1; run("R11");
        dir = 2'b10; run("R11");
        // R12: one lane active, the other isolated
        oe_n = 2'b10; a_in = 16'h11EE; b_in = 16'h22DD; run("R12");
        oe_n = 2'b01; sel_ab = '0; sel_ba = '0; run("R12");
        // R3: both lanes drive B
        oe_n = 2'b00; dir = 2'b11; run("R3");
        // R5: random traffic
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom;
            oe_n = r[1:0]; dir = r[3:2]; cap_ab = r[5:4]; cap_ba = r[7:6];
            sel_ab = r[9:8]; sel_ba = r[11:10];
            a_in = 16'($urandom); b_in = 16'($urandom);
            run("R5");
        end
        finish_run();
    end
endmodule